// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Registers

This block keeps the digital codes for two 12-bit DAC channels. Each channel has two registers. The staging (input) register is written over a simple register-write bus. The live (output) register drives the converter code pin. Software first fills the staging registers. It then writes a load strobe register that has one select bit per channel. Every selected staging register is copied into its live register on the same clock edge, so the two channels can change together.

The load strobe acts only at the moment it is written and holds no state. Reading its address always returns zero. A control register holds one power-down bit per channel, and each bit is driven out as a pin. A set power-down bit does not block writes to any code register. A live register can also be written directly, which skips the staging step. All register words are 16 bits wide. The codes sit in bits [11:0], and bits [15:12] always read back as zero.

Top module: `dacbank_top`

## Requirements
- R1: While rst_n is low, and right after it is released, every staging register, live register and power-down bit reads zero, and code_a, code_b and pwr_down are zero.
- R2: A bus write (wr_en high) to address 0 (channel A staging) or address 1 (channel B staging) stores wr_data[11:0]. The value reads back with bits [15:12] as zero. When wr_en is low, nothing is stored.
- R3: A write to a staging register does not change code_a or code_b.
- R4: A write to address 5 (load strobe) with bit 0 set copies channel A staging into code_a on that edge. If bit 1 is clear, code_b keeps its value.
- R5: A load strobe write with bit 1 set copies channel B staging into code_b on that edge. If bit 0 is clear, code_a keeps its value.
- R6: A load strobe write with both bits set updates code_a and code_b on the same edge.
- R7: Load strobe bits [15:2] have no effect. A load write with bits [1:0] = 00 changes nothing.
- R8: Reading address 5 returns 0 at all times. A load write leaves no stored value.
- R9: A write to address 2 (channel A live) or address 3 (channel B live) sets that code output directly from wr_data[11:0]. Addresses 2 and 3 read back the live codes. When a load strobe and a direct live write name the same channel on the same edge, the load wins.
- R10: Address 4 is the control register. Bit 0 drives pwr_down[0] (channel A) and bit 1 drives pwr_down[1] (channel B). It reads back those two bits, with bits [15:2] as zero.
- R11: Staging writes, live writes and loads all take effect while a channel's power-down bit is set.
- R12: Writes to addresses 6 and 7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write enable |
| wr_addr | input | 3 | Bus write address |
| wr_data | input | 16 | Bus write data word |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| code_a | output | 12 | Live code, channel A |
| code_b | output | 12 | Live code, channel B |
| pwr_down | output | 2 | Power-down controls, bit 0 channel A, bit 1 channel B |

## Verification
Some behaviours are checked by assertions on every cycle. After any load event, a live code must equal the staging value from the cycle before. A live code must hold when neither a load nor a direct write targets it. A dual load must move both channels on one edge. The load address and the unmapped addresses must read zero. The power-down pins must follow the last control write. Other behaviours only the bench's scenarios can show: that the strobe's upper bits select nothing, that writes land while power-down is set, that wr_en low blocks a write, and that reset clears registers already holding data.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int NCH    = 2;
  localparam int CODE_W = 12;
  localparam int DATA_W = 16;
  localparam int NREG   = 2 * NCH + 2;
  localparam int ADDR_W = $clog2(NREG + 2);

  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(2 * NCH);
  localparam logic [ADDR_W-1:0] ADR_LOAD = ADDR_W'(2 * NCH + 1);

  function automatic logic [ADDR_W-1:0] adr_stage(input int ch);
    return ADDR_W'(ch);
  endfunction

  function automatic logic [ADDR_W-1:0] adr_live(input int ch);
    return ADDR_W'(NCH + ch);
  endfunction

  // Code field of a bus word.
  function automatic logic [CODE_W-1:0] code_of(input logic [DATA_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  // Widen a code to a bus word, spare bits zero.
  function automatic logic [DATA_W-1:0] word_of(input logic [CODE_W-1:0] c);
    return {{(DATA_W-CODE_W){1'b0}}, c};
  endfunction

  // Channel select bits carried by a load strobe word.
  function automatic logic [NCH-1:0] sel_of(input logic [DATA_W-1:0] w);
    return w[NCH-1:0];
  endfunction
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    stage_we,
  output logic [NCH-1:0]    live_we,
  output logic [NCH-1:0]    load_ev,
  output logic              ctrl_we
);
  logic load_hit;
  assign load_hit = wr_en && (wr_addr == ADR_LOAD);
  assign ctrl_we  = wr_en && (wr_addr == ADR_CTRL);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_STG  = adr_stage(ch);
    localparam logic [ADDR_W-1:0] A_LIVE = adr_live(ch);
    assign stage_we[ch] = wr_en && (wr_addr == A_STG);
    assign live_we[ch]  = wr_en && (wr_addr == A_LIVE);
    assign load_ev[ch]  = load_hit && sel_of(wr_data)[ch];
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic              live_we,
  input  logic              load_ev,
  input  logic [CODE_W-1:0] wcode,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] live_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (stage_we) stage_q <= wcode;
      if (load_ev)      live_q <= stage_q;   // load wins over direct write
      else if (live_we) live_q <= wcode;
    end
  end

  assert_load_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> live_q == $past(stage_q));
  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !live_we) |=> $stable(live_q));
  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_we |=> $stable(stage_q));
  assert_direct_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_we && !load_ev) |=> live_q == $past(wcode));
endmodule

// File: rtl/dacbank_rdmux.sv
module dacbank_rdmux
  import dacbank_pkg::*;
(
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [NCH-1:0][CODE_W-1:0]  stage_q,
  input  logic [NCH-1:0][CODE_W-1:0]  live_q,
  input  logic [NCH-1:0]              pd_q,
  output logic [DATA_W-1:0]           rd_data
);
  always_comb begin
    rd_data = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (rd_addr == adr_stage(ch)) rd_data = word_of(stage_q[ch]);
      if (rd_addr == adr_live(ch))  rd_data = word_of(live_q[ch]);
    end
    if (rd_addr == ADR_CTRL) rd_data = {{(DATA_W-NCH){1'b0}}, pd_q};
  end

  always_comb begin
    if (rd_addr == ADR_LOAD)
      assert_load_reads_zero_R8: assert (rd_data == '0);
    if (int'(rd_addr) >= NREG)
      assert_unmapped_zero_R12: assert (rd_data == '0);
  end
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic [11:0] code_a,
  output logic [11:0] code_b,
  output logic [1:0]  pwr_down
);
  logic [NCH-1:0]             stage_we, live_we, load_ev;
  logic                       ctrl_we;
  logic [NCH-1:0][CODE_W-1:0] stage_q, live_q;
  logic [NCH-1:0]             pd_q;
  logic                       unused_hi;

  assign unused_hi = &{1'b0, wr_data[DATA_W-1:CODE_W]};

  dacbank_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stage_we(stage_we), .live_we(live_we), .load_ev(load_ev), .ctrl_we(ctrl_we)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dacbank_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .stage_we(stage_we[ch]), .live_we(live_we[ch]), .load_ev(load_ev[ch]),
      .wcode(code_of(wr_data)),
      .stage_q(stage_q[ch]), .live_q(live_q[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pd_q <= '0;
    else if (ctrl_we) pd_q <= sel_of(wr_data);
  end

  dacbank_rdmux u_rd (
    .rd_addr(rd_addr), .stage_q(stage_q), .live_q(live_q),
    .pd_q(pd_q), .rd_data(rd_data)
  );

  assign code_a   = live_q[0];
  assign code_b   = live_q[1];
  assign pwr_down = pd_q;

  assert_pair_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&load_ev) |=> (code_a == $past(stage_q[0])) && (code_b == $past(stage_q[1])));
  assert_pd_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> pwr_down == $past(wr_data[1:0]));
  assert_pd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(pwr_down));
endmodule

// File: tb/tb_dacbank_top.sv
module tb_dacbank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [11:0] code_a, code_b;
  logic [1:0]  pwr_down;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dacbank_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .code_a(code_a), .code_b(code_b), .pwr_down(pwr_down)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [2:0]  adr;
    logic [15:0] dat;
    logic [2:0]  rda;
    logic [11:0] ea;
    logic [11:0] eb;
    logic [1:0]  epd;
    logic [15:0] erd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  1'b1, 3'd0, 16'hF123, 3'd0, 12'h000, 12'h000, 2'd0, 16'h0123}, // R2 R3
    '{4'd2,  1'b1, 3'd1, 16'h0ABC, 3'd1, 12'h000, 12'h000, 2'd0, 16'h0ABC}, // R2
    '{4'd4,  1'b1, 3'd5, 16'h0001, 3'd2, 12'h123, 12'h000, 2'd0, 16'h0123}, // R4
    '{4'd7,  1'b1, 3'd5, 16'hFFFC, 3'd3, 12'h123, 12'h000, 2'd0, 16'h0000}, // R7
    '{4'd5,  1'b1, 3'd5, 16'h0002, 3'd5, 12'h123, 12'hABC, 2'd0, 16'h0000}, // R5 R8
    '{4'd3,  1'b1, 3'd0, 16'h0456, 3'd0, 12'h123, 12'hABC, 2'd0, 16'h0456}, // R3
    '{4'd3,  1'b1, 3'd1, 16'h8789, 3'd1, 12'h123, 12'hABC, 2'd0, 16'h0789}, // R3
    '{4'd6,  1'b1, 3'd5, 16'h0003, 3'd3, 12'h456, 12'h789, 2'd0, 16'h0789}, // R6
    '{4'd9,  1'b1, 3'd2, 16'h0111, 3'd2, 12'h111, 12'h789, 2'd0, 16'h0111}, // R9
    '{4'd10, 1'b1, 3'd4, 16'hFFFF, 3'd4, 12'h111, 12'h789, 2'd3, 16'h0003}, // R10
    '{4'd11, 1'b1, 3'd0, 16'h0222, 3'd0, 12'h111, 12'h789, 2'd3, 16'h0222}, // R11
    '{4'd11, 1'b1, 3'd3, 16'h0333, 3'd3, 12'h111, 12'h333, 2'd3, 16'h0333}, // R11
    '{4'd11, 1'b1, 3'd5, 16'h0001, 3'd2, 12'h222, 12'h333, 2'd3, 16'h0222}, // R11
    '{4'd12, 1'b1, 3'd6, 16'hFFFF, 3'd6, 12'h222, 12'h333, 2'd3, 16'h0000}, // R12
    '{4'd12, 1'b1, 3'd7, 16'hFFFF, 3'd7, 12'h222, 12'h333, 2'd3, 16'h0000}, // R12
    '{4'd2,  1'b0, 3'd0, 16'h0FFF, 3'd0, 12'h222, 12'h333, 2'd3, 16'h0222}, // R2
    '{4'd10, 1'b1, 3'd4, 16'h0002, 3'd4, 12'h222, 12'h333, 2'd2, 16'h0002}  // R10
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                      input logic [2:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic check_all_zero(input string tag);
    check({tag, " code_a"}, {4'h0, code_a}, 16'h0);
    check({tag, " code_b"}, {4'h0, code_b}, 16'h0);
    check({tag, " pwr_down"}, {14'h0, pwr_down}, 16'h0);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #0.1;
      check($sformatf("%s read %0d", tag, r), rd_data, 16'h0);
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all_zero("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all_zero("R1 after release");

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].we, TBL[i].adr, TBL[i].dat, TBL[i].rda);
      check($sformatf("R%0d row %0d code_a", TBL[i].req, i), {4'h0, code_a}, {4'h0, TBL[i].ea});
      check($sformatf("R%0d row %0d code_b", TBL[i].req, i), {4'h0, code_b}, {4'h0, TBL[i].eb});
      check($sformatf("R%0d row %0d pwr_down", TBL[i].req, i), {14'h0, pwr_down}, {14'h0, TBL[i].epd});
      check($sformatf("R%0d row %0d rd_data", TBL[i].req, i), rd_data, TBL[i].erd);
    end

    // R8: load word leaves nothing behind; a zero-select load changes nothing
    step(1'b1, 3'd5, 16'h0000, 3'd5);
    check("R8 load readback", rd_data, 16'h0000);
    check("R8 code_a after null load", {4'h0, code_a}, 16'h0222);
    check("R7 code_b after null load", {4'h0, code_b}, 16'h0333);

    // R1: reset with registers holding data
    @(negedge clk); rst_n = 1'b0;
    #1;
    check_all_zero("R1 mid-run reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all_zero("R1 mid-run release");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule